// File: doc/BRIEF.md
# Masked-Write Open-Drain Pad Register

This block is a single control word for a pair of open-drain pins, one carrying a two-wire bus clock and one carrying its data, that software toggles directly to generate the bus waveform. Each pin has a stored direction bit and a stored drive-value bit. Each of those two fields is guarded by its own write-strobe bit in the same write word, so one write can change one field of one pin and leave every other field as it was.

A pin is pulled low by selecting output direction with a value of 0. It is let go high by selecting input direction, after which the external pull-up raises the line. The level on each pin passes through a two-flop synchroniser and can be read back in a read-only bit. Each pin also has a pull-up disable bit. This is a plain configuration bit that reads back as written, so a read-modify-write keeps it intact. Bus timing is left entirely to software.

Top module: `odPadReg`

## Requirements
- R1: After reset, both pad output enables are 0 and both pad output values are 0. Both pull-up enables are 1. Each synchroniser holds 1. The read word is therefore 0x00001010.
- R2: Each pin occupies one 8-bit lane: the clock pin uses bits 7:0 and the data pin uses bits 15:8. Within a lane, bit 1 is the stored direction (1 = drive, 0 = release). On a write, this bit takes the written value only when lane bit 0 (the direction strobe) is 1. Otherwise it keeps its old value.
- R3: Within a lane, bit 3 is the stored drive value. On a write, this bit takes the written value only when lane bit 2 (the value strobe) is 1. Otherwise it keeps its old value.
- R4: A pad output enable always equals that pin's stored direction, and a pad output value always equals its stored drive value. Both change on the clock edge that accepts the write.
- R5: A write with direction strobe 1, direction 1, value strobe 1 and value 0 (lane pattern 0x07) makes the pin drive low.
- R6: Lane bit 4 is read-only. It returns the pad input level delayed by two clock edges.
- R7: Lane bit 5 is the pull-up disable. It is loaded on every write and reads back as written. The pull-up enable output is its inverse.
- R8: The strobe bits (lane bits 0 and 2), lane bits 7:6 and bits 31:16 always read as 0.
- R9: A write changes only the pin whose lane holds set strobe bits. The other pin's direction and value are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write word |
| rdData | output | 32 | Register read word |
| padIn | input | 2 | Pad input levels, bit 0 clock pin, bit 1 data pin |
| padOe | output | 2 | Pad output enables |
| padOut | output | 2 | Pad output values |
| pullEn | output | 2 | Pull-up enables |

## Verification
The write word is tried with four kinds of pattern:
- both strobes set;
- only the direction strobe set;
- only the value strobe set;
- field bits written with no strobe.

Comparing their results separates a correct per-field mask from a shared mask or from no mask at all. Writes aimed at one lane while the other lane holds a distinct state show whether the lanes are independent. An all-ones word shows whether any strobe or unused bit leaks into the read path. Steps of the input level, held and toggled, fix the synchroniser latency at exactly two edges, not one or three.

// File: rtl/odPadPkg.sv
package odPadPkg;
  localparam int LANE_W       = 8;
  localparam int DIR_MASK_BIT = 0;
  localparam int DIR_BIT      = 1;
  localparam int VAL_MASK_BIT = 2;
  localparam int VAL_BIT      = 3;
  localparam int VAL_IN_BIT   = 4;
  localparam int PULL_DIS_BIT = 5;

  typedef struct packed {
    logic dirWe;
    logic dirVal;
    logic valWe;
    logic valVal;
    logic pullWe;
    logic pullVal;
  } padStrobe_t;
endpackage

// File: rtl/odPadSync.sv
module odPadSync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

  localparam int AGE_W = $clog2(STAGES + 1);
  logic [AGE_W-1:0] ageCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ageCnt <= '0;
    else if (ageCnt != AGE_W'(STAGES))  ageCnt <= ageCnt + 1'b1;
  end

  generate
    if (STAGES == 2) begin : gChk
      AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
        (ageCnt == AGE_W'(STAGES)) |-> (syncOut == $past(asyncIn, 2))); // R6
    end
  endgenerate
endmodule

// File: rtl/odPadCtrl.sv
module odPadCtrl
  import odPadPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 2
) (
  input  logic                      wrEn,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_PINS-1:0]       dirQ,
  input  logic [NUM_PINS-1:0]       valQ,
  input  logic [NUM_PINS-1:0]       pullDisQ,
  input  logic [NUM_PINS-1:0]       valIn,
  output padStrobe_t [NUM_PINS-1:0] strobes,
  output logic [DATA_W-1:0]         rdData
);
  localparam int USED_W = NUM_PINS * LANE_W;

  logic unusedWr;
  assign unusedWr = ^wrData;

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      strobes[p].dirWe   = wrEn & wrData[p*LANE_W + DIR_MASK_BIT];
      strobes[p].dirVal  = wrData[p*LANE_W + DIR_BIT];
      strobes[p].valWe   = wrEn & wrData[p*LANE_W + VAL_MASK_BIT];
      strobes[p].valVal  = wrData[p*LANE_W + VAL_BIT];
      strobes[p].pullWe  = wrEn;
      strobes[p].pullVal = wrData[p*LANE_W + PULL_DIS_BIT];
      rdData[p*LANE_W + DIR_BIT]      = dirQ[p];
      rdData[p*LANE_W + VAL_BIT]      = valQ[p];
      rdData[p*LANE_W + VAL_IN_BIT]   = valIn[p];
      rdData[p*LANE_W + PULL_DIS_BIT] = pullDisQ[p];
    end
  end

  initial begin
    if (DATA_W < USED_W) $error("DATA_W too small for NUM_PINS lanes");
  end
endmodule

// File: rtl/odPadDpath.sv
module odPadDpath
  import odPadPkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  padStrobe_t [NUM_PINS-1:0] strobes,
  input  logic [NUM_PINS-1:0]       padIn,
  output logic [NUM_PINS-1:0]       dirQ,
  output logic [NUM_PINS-1:0]       valQ,
  output logic [NUM_PINS-1:0]       pullDisQ,
  output logic [NUM_PINS-1:0]       valIn
);
  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dirQ[p]     <= 1'b0;
          valQ[p]     <= 1'b0;
          pullDisQ[p] <= 1'b0;
        end else begin
          if (strobes[p].dirWe)  dirQ[p]     <= strobes[p].dirVal;
          if (strobes[p].valWe)  valQ[p]     <= strobes[p].valVal;
          if (strobes[p].pullWe) pullDisQ[p] <= strobes[p].pullVal;
        end
      end

      odPadSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSync (
        .clk(clk), .rstN(rstN), .asyncIn(padIn[p]), .syncOut(valIn[p])
      );

      AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !strobes[p].dirWe |=> $stable(dirQ[p])); // R2
      AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        strobes[p].dirWe |=> (dirQ[p] == $past(strobes[p].dirVal))); // R2
      AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !strobes[p].valWe |=> $stable(valQ[p])); // R3
      AST_VAL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        strobes[p].valWe |=> (valQ[p] == $past(strobes[p].valVal))); // R3
      AST_PULL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        strobes[p].pullWe |=> (pullDisQ[p] == $past(strobes[p].pullVal))); // R7
    end
  endgenerate
endmodule

// File: rtl/odPadReg.sv
module odPadReg
  import odPadPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] pullEn
);
  padStrobe_t [NUM_PINS-1:0] strobes;
  logic [NUM_PINS-1:0] dirQ, valQ, pullDisQ, valIn;

  odPadCtrl #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) uCtrl (
    .wrEn(wrEn), .wrData(wrData), .dirQ(dirQ), .valQ(valQ),
    .pullDisQ(pullDisQ), .valIn(valIn), .strobes(strobes), .rdData(rdData)
  );

  odPadDpath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .padIn(padIn),
    .dirQ(dirQ), .valQ(valQ), .pullDisQ(pullDisQ), .valIn(valIn)
  );

  assign padOe  = dirQ;
  assign padOut = valQ;
  assign pullEn = ~pullDisQ;

  AST_RELEASE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[DIR_MASK_BIT] && !wrData[DIR_BIT]) |=> !padOe[0]); // R4
  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[LANE_W-1:0] == 8'h07) |=> (padOe[0] && !padOut[0])); // R5
endmodule

// File: tb/odPadReg_test.sv
module odPadReg_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  padIn = 2'b11;
  logic [31:0] rdData;
  logic [1:0]  padOe, padOut, pullEn;

  odPadReg uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .pullEn(pullEn)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] rd;
    logic [1:0]  oe;
    logic [1:0]  out;
    logic [1:0]  pu;
    string       tag;
  } expItem_t;

  expItem_t   sb[$];
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 0;

  logic [1:0] mDir = '0, mVal = '0, mPul = '0, mS0 = 2'b11, mS1 = 2'b11;

  task automatic step(input logic we, input logic [31:0] d,
                      input logic [1:0] pin, input string tag);
    expItem_t it;
    @(negedge clk);
    wrEn = we; wrData = d; padIn = pin;
    for (int p = 0; p < 2; p++) begin
      if (we) begin
        if (d[8*p + 0]) mDir[p] = d[8*p + 1];
        if (d[8*p + 2]) mVal[p] = d[8*p + 3];
        mPul[p] = d[8*p + 5];
      end
    end
    mS1 = mS0; mS0 = pin;
    it.rd = '0;
    for (int p = 0; p < 2; p++) begin
      it.rd[8*p + 1] = mDir[p];
      it.rd[8*p + 3] = mVal[p];
      it.rd[8*p + 4] = mS1[p];
      it.rd[8*p + 5] = mPul[p];
    end
    it.oe = mDir; it.out = mVal; it.pu = ~mPul; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk); #1;
      if (sb.size() != 0) begin
        it = sb.pop_front();
        vectors++;
        if (rdData !== it.rd || padOe !== it.oe || padOut !== it.out || pullEn !== it.pu) begin
          miscompares++;
          $display("FAIL %s: rd=%08h oe=%b out=%b pu=%b expected rd=%08h oe=%b out=%b pu=%b",
                   it.tag, rdData, padOe, padOut, pullEn, it.rd, it.oe, it.out, it.pu);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 5000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    vectors = 0;
    miscompares = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    step(1'b0, 32'h0, 2'b11, "R1 reset state");
    step(1'b0, 32'h0, 2'b11, "R1 reset state hold");
    step(1'b1, 32'h0000_0007, 2'b11, "R5 clock pin driven low");
    step(1'b1, 32'h0000_000C, 2'b11, "R3 value strobe only, dir kept (R2)");
    step(1'b1, 32'h0000_0200, 2'b11, "R2 data dir written without strobe");
    step(1'b1, 32'h0000_0001, 2'b11, "R4 clock pin released, value kept");
    step(1'b1, 32'h0000_0700, 2'b11, "R9 data lane driven low, clock lane untouched");
    step(1'b1, 32'h0000_0008, 2'b11, "R3 value bit without strobe ignored");
    step(1'b1, 32'h0000_0404, 2'b11, "R3 value strobes clear both values");
    step(1'b1, 32'h0000_2000, 2'b11, "R7 data pull-up disabled");
    step(1'b1, 32'h0000_0020, 2'b11, "R7 pull bits follow every write");
    step(1'b0, 32'h0000_0000, 2'b10, "R6 clock input low, edge 1");
    step(1'b0, 32'h0000_0000, 2'b10, "R6 clock input low, edge 2");
    step(1'b0, 32'h0000_0000, 2'b01, "R6 inputs swapped, edge 1");
    step(1'b0, 32'h0000_0000, 2'b10, "R6 inputs toggled back");
    step(1'b0, 32'h0000_0000, 2'b11, "R6 toggle pipeline");
    step(1'b0, 32'h0000_0000, 2'b11, "R6 settle high");
    step(1'b1, 32'hFFFF_FFFF, 2'b11, "R8 all-ones write reads masks as 0");
    step(1'b1, 32'h0000_0100, 2'b11, "R9 data released, clock still driven");
    step(1'b1, 32'h0000_0005, 2'b00, "R2 both strobes with zero fields");
    step(1'b1, 32'h0000_0000, 2'b00, "R2 no strobes, state held");
    step(1'b0, 32'h0000_0000, 2'b00, "R6 inputs low reach value-in");
    @(negedge clk); wrEn = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule